// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase lines and the index line of an incremental encoder into a signed-direction step stream and a position count. The three inputs are first brought into the local clock domain. Each legal change of the sampled phase pair then produces a one-cycle count enable and a direction. The position register moves by one on every such enable. In x4 resolution every edge of either phase counts. In x2 resolution only edges of phase A count.

The 3-bit mode selects whether the counter runs, the resolution, and how it wraps. In the limit modes the count folds at a programmable maximum. In the index modes it wraps only at its natural width. In the index modes the count can also be cleared by an index pulse, but only when the phases stand at a programmed level at that moment. The index modes also watch for two forbidden boundary values, which set a sticky error flag and may pulse an error interrupt.

Top module: `qenc_position_top`

## Requirements
- R1: `count_up` is 1 after a counted edge in the direction where phase A leads phase B, i.e. the pair {A,B} steps 00→10→11→01→00. It is 0 after a counted edge in the opposite direction. It holds between counted edges and is 0 after reset.
- R2: In x4 resolution (mode bit 1 = 1), every change of exactly one phase moves `position` by one step, and `position` does not move without such a change. After reset `position` is 0.
- R3: In x2 resolution (mode bit 1 = 0), only changes of phase A move `position`. The direction follows the same A-leads-B rule. Changes of phase B alone leave `position` unchanged.
- R4: A sampled transition in which both phases change at once moves neither `position` nor `count_up`.
- R5: In limit modes 3'b101 (x2) and 3'b111 (x4), an up step from `max_count` gives 0, and a down step from 0 gives `max_count`.
- R6: In index modes 3'b100 (x2) and 3'b110 (x4), the count wraps at its natural width, 0xFFFF↔0. An up step that lands on `max_count`+1, or a down step that lands on 0xFFFF, sets `cnt_err`. Counting then carries on.
- R7: `cnt_err` stays set until a cycle with `err_clr` high. Each error event gives a one-cycle `err_irq` pulse, unless `err_irq_dis` is 1. The natural 0xFFFF→0 wrap gives no pulse.
- R8: In any mode other than 3'b100 and 3'b110, `cnt_err` is never set, even when the count reaches 0xFFFF.
- R9: In an index mode with `idx_rst_en` = 1, a rising index edge whose phase match holds clears `position` to 0. With `idx_rst_en` = 0, or with no match, the index leaves `position` unchanged.
- R10: The phase match in x4 requires phase B = `idx_match[1]` and phase A = `idx_match[0]`. In x2, `idx_match[1]` picks the phase (0 = A, 1 = B) and `idx_match[0]` is its required level.
- R11: In an index mode, every rising index edge gives a one-cycle `index_irq` pulse, matched or not.
- R12: Modes with bit 2 = 0 do not count. `position` holds through any phase activity.
- R13: A phase change applied before clock edge k is reflected in `position` after edge k+2 and not earlier (two synchronizer flops and the count register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| phase_a | input | 1 | Encoder phase A (asynchronous) |
| phase_b | input | 1 | Encoder phase B (asynchronous) |
| index_in | input | 1 | Encoder index (asynchronous) |
| mode | input | 3 | Run / resolution / wrap mode |
| max_count | input | CNT_W | Wrap limit, and error boundary minus one |
| idx_rst_en | input | 1 | Allow a matched index to clear the count |
| idx_match | input | 2 | Phase match value for the index clear |
| err_irq_dis | input | 1 | Suppress the error interrupt pulse |
| err_clr | input | 1 | Clear the sticky error flag |
| count_pulse | output | 1 | One-cycle count enable |
| count_up | output | 1 | Direction of the last counted edge |
| position | output | CNT_W | Position count |
| index_irq | output | 1 | Index event pulse |
| cnt_err | output | 1 | Sticky count error flag |
| err_irq | output | 1 | Count error pulse |

## Verification
A phase or index change lands in `position`, `count_up` and `cnt_err` three clock edges after it is applied. The interrupt pulses are high for the cycle that follows that edge. The bench applies each stimulus on a falling edge, waits four rising edges and then samples on a falling edge, so every result is already settled. One probe samples one edge early and then exactly on time to pin the latency itself. The interrupt pulses are counted on every falling edge and compared with the counts the bench model predicts.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef struct packed {
    logic run;      // counter active
    logic x4;       // 1: both phases counted, 0: phase A only
    logic idx_mode; // index-clear / error-check family
  } qenc_mode_t;

  function automatic qenc_mode_t decode_mode(input logic [2:0] m);
    qenc_mode_t r;
    r.run      = m[2];
    r.x4       = m[1];
    r.idx_mode = m[2] & ~m[0];
    return r;
  endfunction

  // Phase-state qualifier for an index clear.
  function automatic logic index_phase_ok(input logic x4, input logic [1:0] sel,
                                          input logic a, input logic b);
    if (x4) return (a == sel[0]) && (b == sel[1]);
    return ((sel[1] ? b : a) == sel[0]);
  endfunction

  // Direction of a single-phase change, given the new levels.
  function automatic logic edge_is_up(input logic a_moved, input logic a, input logic b);
    return a_moved ? (a ^ b) : ~(a ^ b);
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign d_out = stg[STAGES-1];
endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
  import qenc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  input  logic run,
  input  logic x4,
  output logic step,
  output logic step_up,
  output logic dir_q
);
  logic pa, pb;
  logic da, db, both_moved, edge_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa <= 1'b0;
      pb <= 1'b0;
    end else begin
      pa <= a;
      pb <= b;
    end
  end

  assign da         = a ^ pa;
  assign db         = b ^ pb;
  assign both_moved = da & db;
  assign edge_ok    = x4 ? (da ^ db) : (da & ~db);
  assign step       = run & edge_ok;
  assign step_up    = edge_is_up(da, a, b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dir_q <= 1'b0;
    else if (step) dir_q <= step_up;
  end

  AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    both_moved |-> !step); // R4
  AST_X2_PHASE_A_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!x4 && !da) |-> !step); // R3
  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(dir_q)); // R1
  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !step); // R12
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             step_up,
  input  logic             run,
  input  logic             idx_mode,
  input  logic             idx_rise,
  input  logic             idx_ok,
  input  logic             rst_en,
  input  logic [CNT_W-1:0] max_count,
  input  logic             irq_dis,
  input  logic             err_clr,
  output logic [CNT_W-1:0] pos,
  output logic             cnt_err,
  output logic             err_irq,
  output logic             index_irq
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] next_pos(input logic [CNT_W-1:0] cur,
                                                input logic up,
                                                input logic [CNT_W-1:0] lim,
                                                input logic use_lim);
    if (up) begin
      if (use_lim && cur == lim) return '0;
      return cur + ONE;
    end
    if (use_lim && cur == '0) return lim;
    return cur - ONE;
  endfunction

  logic             use_lim, active_idx, idx_clr, err_hit;
  logic [CNT_W-1:0] nxt, err_up_val;

  assign use_lim    = run & ~idx_mode;
  assign active_idx = run & idx_mode;
  assign nxt        = next_pos(pos, step_up, max_count, use_lim);
  assign err_up_val = max_count + ONE;
  assign idx_clr    = active_idx & rst_en & idx_rise & idx_ok;
  assign err_hit    = active_idx & step & ~idx_clr &
                      (step_up ? (nxt == err_up_val) : (nxt == ALL_ONES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (idx_clr) pos <= '0;
    else if (step)    pos <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_err   <= 1'b0;
      err_irq   <= 1'b0;
      index_irq <= 1'b0;
    end else begin
      if (err_hit)      cnt_err <= 1'b1;
      else if (err_clr) cnt_err <= 1'b0;
      err_irq   <= err_hit & ~irq_dis;
      index_irq <= active_idx & idx_rise;
    end
  end

  AST_POS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !idx_clr) |=> $stable(pos)); // R2
  AST_INDEX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clr |=> (pos == '0)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_err && !err_clr) |=> cnt_err); // R7
  AST_ERR_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> cnt_err); // R7
  AST_NO_ERR_OUTSIDE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_idx && !cnt_err) |=> !cnt_err); // R8
  AST_LIMIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (use_lim && pos <= max_count && !idx_clr) |=> (pos <= $past(max_count))); // R5
endmodule

// File: rtl/qenc_position_top.sv
module qenc_position_top
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_in,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] max_count,
  input  logic             idx_rst_en,
  input  logic [1:0]       idx_match,
  input  logic             err_irq_dis,
  input  logic             err_clr,
  output logic             count_pulse,
  output logic             count_up,
  output logic [CNT_W-1:0] position,
  output logic             index_irq,
  output logic             cnt_err,
  output logic             err_irq
);
  localparam int SYNC_W = 3;

  qenc_mode_t      md;
  logic [SYNC_W-1:0] synced;
  logic            s_a, s_b, s_idx, idx_prev, idx_rise, idx_ok;
  logic            step, step_up;

  assign md = decode_mode(mode);

  qenc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({index_in, phase_b, phase_a}),
    .d_out (synced)
  );
  assign s_a   = synced[0];
  assign s_b   = synced[1];
  assign s_idx = synced[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_prev <= 1'b0;
    else        idx_prev <= s_idx;
  end
  assign idx_rise = s_idx & ~idx_prev;
  assign idx_ok   = index_phase_ok(md.x4, idx_match, s_a, s_b);

  qenc_decoder dec_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .a       (s_a),
    .b       (s_b),
    .run     (md.run),
    .x4      (md.x4),
    .step    (step),
    .step_up (step_up),
    .dir_q   (count_up)
  );

  qenc_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .step_up   (step_up),
    .run       (md.run),
    .idx_mode  (md.idx_mode),
    .idx_rise  (idx_rise),
    .idx_ok    (idx_ok),
    .rst_en    (idx_rst_en),
    .max_count (max_count),
    .irq_dis   (err_irq_dis),
    .err_clr   (err_clr),
    .pos       (position),
    .cnt_err   (cnt_err),
    .err_irq   (err_irq),
    .index_irq (index_irq)
  );

  assign count_pulse = step;

  AST_INDEX_IRQ_ONLY_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (!md.idx_mode && !idx_rise) |=> !index_irq); // R11
endmodule

// File: tb/qenc_position_top_tb_top.sv
module qenc_position_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_a = 1'b0, phase_b = 1'b0, index_in = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [15:0] max_count = 16'd5;
  logic        idx_rst_en = 1'b0;
  logic [1:0]  idx_match = 2'b00;
  logic        err_irq_dis = 1'b0, err_clr = 1'b0;
  logic        count_pulse, count_up, index_irq, cnt_err, err_irq;
  logic [15:0] position;

  always #10 clk = ~clk;

  qenc_position_top dut_i (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .index_in(index_in), .mode(mode), .max_count(max_count),
    .idx_rst_en(idx_rst_en), .idx_match(idx_match), .err_irq_dis(err_irq_dis),
    .err_clr(err_clr), .count_pulse(count_pulse), .count_up(count_up),
    .position(position), .index_irq(index_irq), .cnt_err(cnt_err), .err_irq(err_irq)
  );

  int n_chk = 0, n_fail = 0;
  int seen_err_irq = 0, seen_idx_irq = 0;
  int exp_err_irq = 0, exp_idx_irq = 0;
  logic [15:0] m_pos = 16'd0;
  logic        m_dir = 1'b0, m_err = 1'b0;
  logic        ca = 1'b0, cb = 1'b0;
  bit          done = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (err_irq)   seen_err_irq++;
    if (index_irq) seen_idx_irq++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // Model of one applied phase pair; returns through m_* state.
  task automatic model_move(input logic na, input logic nb);
    logic da, db, cnt, up, run, x4, im;
    int lim;
    da = na ^ ca; db = nb ^ cb;
    run = mode[2]; x4 = mode[1]; im = mode[2] & ~mode[0];
    cnt = run && (x4 ? (da != db) : (da && !db));
    up  = da ? (na != nb) : (na == nb);
    if (cnt) begin
      m_dir = up;
      if (im) begin
        m_pos = up ? m_pos + 16'd1 : m_pos - 16'd1;
        if ((up && m_pos == max_count + 16'd1) || (!up && m_pos == 16'hFFFF)) begin
          m_err = 1'b1;
          if (!err_irq_dis) exp_err_irq++;
        end
      end else begin
        lim = int'(max_count) + 1;
        m_pos = up ? 16'((int'(m_pos) + 1) % lim) : 16'((int'(m_pos) + lim - 1) % lim);
      end
    end
    ca = na; cb = nb;
  endtask

  task automatic move(input logic na, input logic nb, input string req);
    model_move(na, nb);
    @(negedge clk);
    phase_a = na; phase_b = nb;
    settle();
    chk(req, position, m_pos);
    chk("R1", count_up, m_dir);
  endtask

  task automatic fwd(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      int k;
      k = ca ? (cb ? 2 : 1) : (cb ? 3 : 0);
      k = (k + 1) % 4;
      move(k == 1 || k == 2, k >= 2, req);
    end
  endtask

  task automatic rev(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      int k;
      k = ca ? (cb ? 2 : 1) : (cb ? 3 : 0);
      k = (k + 3) % 4;
      move(k == 1 || k == 2, k >= 2, req);
    end
  endtask

  task automatic pulse_index(input string req);
    logic im, ok;
    im = mode[2] & ~mode[0];
    ok = mode[1] ? (ca == idx_match[0] && cb == idx_match[1])
                 : ((idx_match[1] ? cb : ca) == idx_match[0]);
    if (im && idx_rst_en && ok) m_pos = 16'd0;
    if (im) exp_idx_irq++;
    @(negedge clk); index_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); index_in = 1'b0;
    settle();
    chk(req, position, m_pos);
    chk("R11", seen_idx_irq, exp_idx_irq);
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    m_err = 1'b0;
    settle();
    chk("R7", cnt_err, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R13 actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    settle();
    chk("R2", position, 16'd0);
    chk("R1", count_up, 1'b0);
    chk("R7", cnt_err, 1'b0);

    // R13 latency probe in x4 limit mode
    mode = 3'b111; max_count = 16'd5;
    @(negedge clk); phase_a = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R13", position, 16'd0);
    @(posedge clk); @(negedge clk);
    chk("R13", position, 16'd1);
    ca = 1'b1; m_pos = 16'd1; m_dir = 1'b1;

    // R2 / R5 x4 limit wrap both ways
    fwd(9, "R5");
    rev(8, "R5");
    chk("R8", cnt_err, 1'b0);

    // R4 both phases at once
    move(~ca, ~cb, "R4");
    fwd(2, "R2");

    // R3 x2 limit mode
    mode = 3'b101;
    fwd(8, "R3");
    rev(5, "R3");

    // R12 stopped modes
    mode = 3'b011; fwd(4, "R12");
    mode = 3'b000; rev(3, "R12");

    // R8 limit mode reaching 0xFFFF never flags
    mode = 3'b111; max_count = 16'hFFFF;
    rev(int'(m_pos) + 1, "R5");
    chk("R8", position, 16'hFFFF);
    chk("R8", cnt_err, 1'b0);
    fwd(1, "R5");

    // R6 index mode x4, error on max+1 going up
    mode = 3'b110; max_count = 16'd5; idx_rst_en = 1'b0;
    fwd(8, "R6");
    chk("R6", cnt_err, m_err);
    chk("R7", seen_err_irq, exp_err_irq);
    clear_err();
    rev(int'(m_pos) + 1, "R6");
    chk("R6", cnt_err, 1'b1);
    chk("R7", seen_err_irq, exp_err_irq);
    fwd(2, "R6");
    chk("R7", seen_err_irq, exp_err_irq);
    clear_err();

    // R7 interrupt disabled, flag still set
    err_irq_dis = 1'b1;
    fwd(6, "R6");
    chk("R7", cnt_err, 1'b1);
    chk("R7", seen_err_irq, exp_err_irq);
    err_irq_dis = 1'b0;
    clear_err();

    // R9 / R10 index clears in x4
    idx_rst_en = 1'b1;
    idx_match = {cb, ca};
    pulse_index("R9");
    fwd(3, "R2");
    idx_match = {~cb, ca};
    pulse_index("R10");
    idx_match = {cb, ca};
    idx_rst_en = 1'b0;
    pulse_index("R9");
    idx_rst_en = 1'b1;

    // R10 x2 selection
    mode = 3'b100;
    fwd(3, "R3");
    idx_match = {1'b1, cb};
    pulse_index("R10");
    fwd(4, "R3");
    idx_match = {1'b0, ~ca};
    pulse_index("R10");
    idx_match = {1'b0, ca};
    pulse_index("R10");

    // R11 no index pulse outside index modes
    mode = 3'b111;
    pulse_index("R11");
    chk("R7", seen_err_irq, exp_err_irq);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule